// File: doc/BRIEF.md
# Scalar Half-Precision Square Root with Lane Merge

This unit takes the square root of a single IEEE 754 binary16 number and places the result in the lowest 16-bit lane of a 128-bit vector result. The number being rooted is the low lane of `root_src`. The seven upper lanes of the result come unchanged from a different vector, `upper_src`. A one-bit lane mask decides whether the low lane receives the root. When the mask is active and clear, the low lane is either forced to zero or keeps a prior value, `prior_low`, which the caller supplies.

An operation begins with a one-cycle `start` pulse. The unit captures every operand in that cycle. It then runs a restoring digit recurrence that yields one root bit per cycle, and after that rounds and merges the result. A single-cycle `done` pulse marks the moment when `result` and the three status flags are valid. They hold that value until the next operation completes. Each operation carries its own rounding mode. The unit reports an invalid operation, an inexact result and a subnormal operand.

Top module: `hsqrt_merge_unit`

## Requirements
- R1: `result[127:16]` equals `upper_src[127:16]` as captured at the accepted `start`. The bits `root_src[127:16]` have no effect on any output.
- R2: When the lane is written and the operand is a positive finite non-zero value, `result[15:0]` is the square root of `root_src[15:0]`, correctly rounded to binary16 under the selected mode.
- R3: Rounding mode encodings: `rnd_mode` 2'b00 is round-to-nearest-even, 2'b01 is toward minus infinity, 2'b10 is toward plus infinity, and 2'b11 is toward zero. For a positive root, 2'b01 and 2'b11 give the same result.
- R4: `flag_inexact` is set exactly when the delivered root differs from the exact root. An exact root, such as sqrt(4.0) = 2.0 (0x4400 to 0x4000), leaves it clear.
- R5: An input of +0 (0x0000) or -0 (0x8000) returns the same signed zero. An input of +infinity (0x7C00) returns +infinity. None of these raises a flag.
- R6: A negative input other than -0 returns the default quiet NaN 0x7E00 and sets `flag_invalid`. This includes -infinity and negative subnormals.
- R7: A NaN has exponent field all ones and a non-zero fraction. A quiet NaN (fraction bit 9 set) is passed through unchanged and raises no flag. A signalling NaN (bit 9 clear) is returned with bit 9 set and raises `flag_invalid`.
- R8: A subnormal operand (exponent field zero, non-zero fraction) sets `flag_denorm`. A positive subnormal still yields a correctly rounded normal root.
- R9: The lane is written when `mask_on` is 0 or `lane_mask` is 1. When the lane is not written, `result[15:0]` is 0 if `zero_on` is 1, or `prior_low` if `zero_on` is 0, and all three flags are 0.
- R10: `done` is a one-cycle pulse on the 14th rising edge, counting the edge that accepts `start` as the first. The unit captures its inputs at acceptance and ignores `start` while it is busy. `result` and the flags change only on the edge that raises `done`.
- R11: After reset, `result` is zero, and `done` and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| upper_src | input | 128 | Source of result bits 127:16 |
| root_src | input | 128 | Low lane holds the binary16 operand to be rooted |
| prior_low | input | 16 | Low-lane value kept in merge mode |
| lane_mask | input | 1 | Mask bit for the low lane |
| mask_on | input | 1 | 1 applies `lane_mask`; 0 always writes the lane |
| zero_on | input | 1 | 1 zeroes an unwritten lane; 0 keeps `prior_low` |
| rnd_mode | input | 2 | Rounding mode for this operation |
| result | output | 128 | Merged destination vector |
| done | output | 1 | One-cycle completion pulse |
| flag_invalid | output | 1 | Invalid operation |
| flag_inexact | output | 1 | Result was rounded |
| flag_denorm | output | 1 | Operand was subnormal |

## Verification
The risky overlap is exception detection and lane masking, because both act in the same completion cycle. A signalling NaN or negative operand would raise `flag_invalid` in that cycle, while the mask decides in the same cycle that the lane is not written. The bench issues such operands with the mask active and clear, in both zeroing and merging form. It requires the low lane to equal zero or `prior_low` and all flags to read low. A second overlap is a new `start`, plus changed operands, arriving while the recurrence runs. That result must still match the first operation, and no second `done` may appear.

// File: rtl/hsqrt_pkg.sv
// Shared constants and types for the half-precision square root unit.
// Assumes binary16 layout: sign, biased exponent, fraction.
package hsqrt_pkg;
    localparam int LANE_W = 16;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 10;
    localparam int BIAS   = 15;
    // root bits produced: hidden bit, fraction bits, one guard bit
    localparam int ITER   = FRAC_W + 2;
    localparam int RAD_W  = 2 * ITER;
    localparam int REM_W  = ITER + 4;
    localparam int LAT    = ITER + 2;

    localparam logic [LANE_W-1:0] DEF_QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } st_e;
endpackage

// File: rtl/hsqrt_classify.sv
// Operand classifier. Decides whether the operand takes a special-case
// result (zero, infinity, NaN, negative). Otherwise it normalises the
// significand, makes the exponent even and produces the radicand for
// the recurrence together with the biased result exponent.
// Assumes a purely combinational use in the start cycle.
module hsqrt_classify import hsqrt_pkg::*; (
    input  logic [LANE_W-1:0] op,
    output logic              special,
    output logic [LANE_W-1:0] spec_val,
    output logic              raise_inv,
    output logic              raise_den,
    output logic [RAD_W-1:0]  radicand,
    output logic [EXP_W-1:0]  res_exp
);
    localparam int SE_W = EXP_W + 3;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_max, ex_zero, fr_zero;
    int                lz;
    logic [FRAC_W:0]   mant;
    logic [FRAC_W+1:0] madj;
    logic signed [SE_W-1:0] ue, ue_even, half_e;

    assign sgn     = op[LANE_W-1];
    assign ex      = op[LANE_W-2:FRAC_W];
    assign fr      = op[FRAC_W-1:0];
    assign ex_max  = &ex;
    assign ex_zero = ~|ex;
    assign fr_zero = ~|fr;

    // leading-zero count of the fraction (highest set bit wins)
    always_comb begin
        lz = 0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (fr[i]) lz = FRAC_W - 1 - i;
        end
    end

    // normalise the significand and pick an even exponent
    always_comb begin
        if (ex_zero) begin
            mant = {1'b0, fr} << (lz + 1);
            ue   = SE_W'(-BIAS - lz);
        end else begin
            mant = {1'b1, fr};
            ue   = SE_W'(int'(ex) - BIAS);
        end
        if (ue[0]) begin
            madj    = {mant, 1'b0};
            ue_even = ue - SE_W'(1);
        end else begin
            madj    = {1'b0, mant};
            ue_even = ue;
        end
        half_e   = ue_even >>> 1;
        res_exp  = half_e[EXP_W-1:0] + EXP_W'(BIAS);
        radicand = {madj, {ITER{1'b0}}};
    end

    // special-case results and invalid detection
    always_comb begin
        special   = 1'b1;
        spec_val  = op;
        raise_inv = 1'b0;
        if (ex_max) begin
            if (fr_zero) begin
                if (sgn) begin
                    spec_val  = DEF_QNAN;
                    raise_inv = 1'b1;
                end
            end else if (!fr[FRAC_W-1]) begin
                spec_val  = op | (LANE_W'(1) << (FRAC_W - 1));
                raise_inv = 1'b1;
            end
        end else if (ex_zero && fr_zero) begin
            spec_val = op;
        end else if (sgn) begin
            spec_val  = DEF_QNAN;
            raise_inv = 1'b1;
        end else begin
            special = 1'b0;
        end
    end

    assign raise_den = ex_zero & ~fr_zero;
endmodule

// File: rtl/hsqrt_root_core.sv
// Restoring square-root recurrence. Each step consumes two radicand
// bits and yields one root bit, MSB first. After ITER steps `root_q`
// holds the truncated root and `rem_nz` flags a non-zero remainder.
// Assumes `load` and `step` are never high together.
module hsqrt_root_core import hsqrt_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [RAD_W-1:0] rad_in,
    output logic [ITER-1:0]  root_q,
    output logic             rem_nz
);
    logic [RAD_W-1:0] rad;
    logic [REM_W-1:0] rem, rem_sh, trial, rem_nx;
    logic             fits;

    // one trial subtraction of the recurrence
    always_comb begin
        rem_sh = {rem[REM_W-3:0], rad[RAD_W-1 -: 2]};
        trial  = REM_W'({root_q, 2'b01});
        fits   = rem_sh >= trial;
        rem_nx = fits ? rem_sh - trial : rem_sh;
    end

    // recurrence state: radicand shifter, partial root and remainder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad    <= '0;
            root_q <= '0;
            rem    <= '0;
        end else if (load) begin
            rad    <= rad_in;
            root_q <= '0;
            rem    <= '0;
        end else if (step) begin
            rad    <= rad << 2;
            root_q <= {root_q[ITER-2:0], fits};
            rem    <= rem_nx;
        end
    end

    assign rem_nz = |rem;
endmodule

// File: rtl/hsqrt_round_pack.sv
// Rounds the root (hidden bit, fraction, guard) with the remainder as
// sticky information and packs a positive binary16 result. If the
// rounding carry reaches 2.0, the exponent is bumped.
// Assumes the root lies in [1, 2) and the exponent leaves headroom.
module hsqrt_round_pack import hsqrt_pkg::*; (
    input  logic [ITER-1:0]   root_q,
    input  logic              sticky,
    input  rnd_e              mode,
    input  logic [EXP_W-1:0]  exp_in,
    output logic [LANE_W-1:0] packed_out,
    output logic              inexact
);
    logic              guard, lsb, up, carry;
    logic [FRAC_W+1:0] sig;
    logic              unused_hidden;

    assign guard = root_q[0];
    assign lsb   = root_q[1];

    // increment decision for each rounding mode
    always_comb begin
        case (mode)
            RND_NEAR: up = guard & (sticky | lsb);
            RND_UP:   up = guard | sticky;
            default:  up = 1'b0;
        endcase
    end

    assign sig           = {1'b0, root_q[ITER-1:1]} + (FRAC_W+2)'(up);
    assign carry         = sig[FRAC_W+1];
    assign unused_hidden = sig[FRAC_W];
    assign packed_out    = {1'b0, exp_in + EXP_W'(carry), sig[FRAC_W-1:0]};
    assign inexact       = guard | sticky;
endmodule

// File: rtl/hsqrt_merge_unit.sv
// Top level: scalar binary16 square root merged into a vector result.
// Captures all operands on an accepted start. Runs ITER recurrence
// steps, then a finish cycle that rounds, applies the lane mask (merge
// or zero) and registers the result, the flags and a done pulse.
// Assumes synchronous active-low reset. While busy, start is ignored.
module hsqrt_merge_unit import hsqrt_pkg::*; #(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  upper_src,
    input  logic [VEC_W-1:0]  root_src,
    input  logic [LANE_W-1:0] prior_low,
    input  logic              lane_mask,
    input  logic              mask_on,
    input  logic              zero_on,
    input  logic [1:0]        rnd_mode,
    output logic [VEC_W-1:0]  result,
    output logic              done,
    output logic              flag_invalid,
    output logic              flag_inexact,
    output logic              flag_denorm
);
    localparam int UP_W  = VEC_W - LANE_W;
    localparam int CNT_W = $clog2(ITER);

    st_e               st;
    logic [CNT_W-1:0]  cnt;
    logic              accept;
    logic [UP_W-1:0]   hi_q;
    logic [LANE_W-1:0] prior_q, spec_q, low_val, rounded;
    logic              wr_q, zero_q, spec_f, inv_q, den_q;
    rnd_e              rnd_q;
    logic [EXP_W-1:0]  exp_q;

    logic              c_special, c_inv, c_den;
    logic [LANE_W-1:0] c_spec_val;
    logic [RAD_W-1:0]  c_rad;
    logic [EXP_W-1:0]  c_exp;
    logic [ITER-1:0]   root_q;
    logic              rem_nz, inexact_w;
    logic              unused_hi;

    assign unused_hi = ^root_src[VEC_W-1:LANE_W];
    assign accept    = start && (st == ST_IDLE);

    hsqrt_classify i_cls (
        .op        (root_src[LANE_W-1:0]),
        .special   (c_special),
        .spec_val  (c_spec_val),
        .raise_inv (c_inv),
        .raise_den (c_den),
        .radicand  (c_rad),
        .res_exp   (c_exp)
    );

    hsqrt_root_core i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (st == ST_RUN),
        .rad_in (c_rad),
        .root_q (root_q),
        .rem_nz (rem_nz)
    );

    hsqrt_round_pack i_rnd (
        .root_q     (root_q),
        .sticky     (rem_nz),
        .mode       (rnd_q),
        .exp_in     (exp_q),
        .packed_out (rounded),
        .inexact    (inexact_w)
    );

    // sequencer: idle -> ITER recurrence steps -> finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    st  <= ST_RUN;
                    cnt <= CNT_W'(ITER - 1);
                end
                ST_RUN: begin
                    if (cnt == '0) st <= ST_FIN;
                    else           cnt <= cnt - CNT_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // capture of operands and of the special-case decision at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            prior_q <= '0;
            spec_q  <= '0;
            wr_q    <= 1'b0;
            zero_q  <= 1'b0;
            spec_f  <= 1'b0;
            inv_q   <= 1'b0;
            den_q   <= 1'b0;
            rnd_q   <= RND_NEAR;
            exp_q   <= '0;
        end else if (accept) begin
            hi_q    <= upper_src[VEC_W-1:LANE_W];
            prior_q <= prior_low;
            spec_q  <= c_spec_val;
            wr_q    <= ~mask_on | lane_mask;
            zero_q  <= zero_on;
            spec_f  <= c_special;
            inv_q   <= c_inv;
            den_q   <= c_den;
            rnd_q   <= rnd_e'(rnd_mode);
            exp_q   <= c_exp;
        end
    end

    // low-lane selection: root, special value, zero or prior value
    always_comb begin
        if (!wr_q)       low_val = zero_q ? '0 : prior_q;
        else if (spec_f) low_val = spec_q;
        else             low_val = rounded;
    end

    // output registers, updated only in the finish cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            done         <= 1'b0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ST_FIN) begin
                result       <= {hi_q, low_val};
                done         <= 1'b1;
                flag_invalid <= wr_q & inv_q;
                flag_inexact <= wr_q & ~spec_f & inexact_w;
                flag_denorm  <= wr_q & den_q;
            end
        end
    end
endmodule

// File: rtl/hsqrt_merge_chk.sv
// Checker for hsqrt_merge_unit. It keeps its own model of acceptance
// and latency from the ports alone, and captures the upper lanes and
// the mask decision. Bound to every instance of the top module.
module hsqrt_merge_chk import hsqrt_pkg::*; #(
    parameter int VEC_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VEC_W-1:0]  upper_src,
    input logic              lane_mask,
    input logic              mask_on,
    input logic              zero_on,
    input logic [VEC_W-1:0]  result,
    input logic              done,
    input logic              flag_invalid,
    input logic              flag_inexact,
    input logic              flag_denorm
);
    logic                    busy_c, acc_c, cap_wr, cap_zero;
    logic [7:0]              lat_c;
    logic [VEC_W-1:LANE_W]   cap_hi;

    assign acc_c = start && (!busy_c || done);

    // track acceptance, elapsed cycles and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c   <= 1'b0;
            lat_c    <= '0;
            cap_hi   <= '0;
            cap_wr   <= 1'b0;
            cap_zero <= 1'b0;
        end else if (acc_c) begin
            busy_c   <= 1'b1;
            lat_c    <= 8'd1;
            cap_hi   <= upper_src[VEC_W-1:LANE_W];
            cap_wr   <= ~mask_on | lane_mask;
            cap_zero <= zero_on;
        end else begin
            if (done) busy_c <= 1'b0;
            if (busy_c) lat_c <= lat_c + 8'd1;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_c && lat_c == 8'(LAT)));

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable({flag_invalid, flag_inexact, flag_denorm}));

    // R1
    upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result[VEC_W-1:LANE_W] == cap_hi);

    // R9
    zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_wr && cap_zero) |-> result[LANE_W-1:0] == '0);

    // R9
    quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_wr) |-> !(flag_invalid || flag_inexact || flag_denorm));

    // R6
    invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_invalid) |->
            (&result[LANE_W-2:FRAC_W]) && result[FRAC_W-1]);
endmodule

bind hsqrt_merge_unit hsqrt_merge_chk #(.VEC_W(VEC_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .upper_src    (upper_src),
    .lane_mask    (lane_mask),
    .mask_on      (mask_on),
    .zero_on      (zero_on),
    .result       (result),
    .done         (done),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .flag_denorm  (flag_denorm)
);

// File: tb/test_hsqrt_merge_unit.sv
`timescale 1ns/1ps
module test_hsqrt_merge_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] upper_src = '0, root_src = '0;
    logic [15:0]  prior_low = '0;
    logic         lane_mask = 1'b0, mask_on = 1'b0, zero_on = 1'b0;
    logic [1:0]   rnd_mode = 2'b00;
    logic [127:0] result;
    logic         done, flag_invalid, flag_inexact, flag_denorm;

    int total = 0, bad = 0;
    bit fin = 0;

    always #2.5 clk = ~clk;

    hsqrt_merge_unit i_hsqrt_merge_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .upper_src(upper_src),
        .root_src(root_src), .prior_low(prior_low), .lane_mask(lane_mask),
        .mask_on(mask_on), .zero_on(zero_on), .rnd_mode(rnd_mode),
        .result(result), .done(done), .flag_invalid(flag_invalid),
        .flag_inexact(flag_inexact), .flag_denorm(flag_denorm)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint n);
        longint r = 0;
        for (int b = 22; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= n) r = t;
        end
        return r;
    endfunction

    // arithmetic reference for the low lane and flags (R2..R8)
    function automatic logic [15:0] model(input logic [15:0] x, input logic [1:0] m,
                                          output bit inv, output bit inx, output bit den);
        bit s = x[15];
        int e = int'(x[14:10]);
        int f = int'(x[9:0]);
        longint mm, n, r, rem, kept, d, half;
        int ee, sh, len, drop, pw;
        bit above, tie, exact, up;
        inv = 0; inx = 0; den = (e == 0 && f != 0);
        if (e == 31) begin
            if (f == 0) begin
                if (s) begin inv = 1; return 16'h7E00; end
                return x;
            end
            if (x[9]) return x;
            inv = 1; return x | 16'h0200;
        end
        if (e == 0 && f == 0) return x;
        if (s) begin inv = 1; return 16'h7E00; end
        if (e == 0) begin mm = f; ee = -24; end
        else begin mm = 1024 + f; ee = e - 25; end
        sh = ((ee & 1) != 0) ? 31 : 30;
        n = mm << sh;
        r = isqrt(n);
        rem = n - r * r;
        len = 0;
        for (int b = 0; b < 40; b++) if (((r >> b) & 1) != 0) len = b + 1;
        drop = len - 11;
        kept = r >> drop;
        d = r - (kept << drop);
        half = longint'(1) << (drop - 1);
        above = (d > half) || (d == half && rem != 0);
        tie = (d == half && rem == 0);
        exact = (d == 0 && rem == 0);
        inx = !exact;
        case (m)
            2'b00:   up = above || (tie && kept[0]);
            2'b10:   up = !exact;
            default: up = 0;
        endcase
        kept = kept + (up ? 1 : 0);
        pw = drop + (ee - sh) / 2 + 10;
        if (kept == 2048) begin kept = 1024; pw++; end
        return {1'b0, 5'(pw + 15), 10'(kept - 1024)};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // issue one operation at a negedge, wait for done, return latency
    task automatic run_op(input logic [127:0] up_v, input logic [127:0] rt_v,
                          input logic [15:0] pr, input bit lm, input bit mo,
                          input bit zo, input logic [1:0] md, output int n);
        upper_src = up_v; root_src = rt_v; prior_low = pr;
        lane_mask = lm; mask_on = mo; zero_on = zo; rnd_mode = md;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    // run and compare the full result and flags against the model
    task automatic op_check(input string tag, input logic [127:0] up_v,
                            input logic [15:0] x, input logic [15:0] pr,
                            input bit lm, input bit mo, input bit zo,
                            input logic [1:0] md);
        int n;
        bit inv, inx, den, wr;
        logic [15:0] lo;
        logic [127:0] exp_v;
        logic [2:0] exp_f;
        lo = model(x, md, inv, inx, den);
        wr = !mo || lm;
        if (!wr) lo = zo ? 16'h0000 : pr;
        exp_v = {up_v[127:16], lo};
        exp_f = wr ? {inv, inx, den} : 3'b000;
        run_op(up_v, {rnd128() ^ 128'h0, x} , pr, lm, mo, zo, md, n);
        check(done == 1'b1, tag, "done seen", 128'(done), 128'd1);
        check(result == exp_v && {flag_invalid, flag_inexact, flag_denorm} == exp_f,
              tag, "result+flags",
              {result[127:3], flag_invalid, flag_inexact, flag_denorm},
              {exp_v[127:3], exp_f});
    endtask

    initial begin
        int n;
        logic [15:0] x;
        repeat (4) @(negedge clk);
        // R11 reset state
        check(result == '0, "R11", "result after reset", result, '0);
        check({done, flag_invalid, flag_inexact, flag_denorm} == 4'b0, "R11",
              "done/flags after reset", 128'({done, flag_invalid, flag_inexact, flag_denorm}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 latency and pulse width; R4 exact root
        run_op(128'hA5A5_0000_1111_2222_3333_4444_5555_0000, 128'h0000_4400,
               16'h1234, 1'b1, 1'b1, 1'b0, 2'b00, n);
        check(n == 14, "R10", "latency in cycles", 128'(n), 128'd14);
        check(result[15:0] == 16'h4000 && !flag_inexact, "R4", "sqrt(4.0) exact",
              128'({flag_inexact, result[15:0]}), 128'h4000);
        check(result[127:16] == 112'hA5A5_0000_1111_2222_3333_4444_5555, "R1",
              "upper lanes from upper_src", result, 128'hA5A5_0000_1111_2222_3333_4444_5555_4000);
        @(negedge clk);
        check(done == 1'b0, "R10", "done is one cycle", 128'(done), 128'd0);

        // R4 inexact root: sqrt(2.0)
        op_check("R4", rnd128(), 16'h4000, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        check(flag_inexact == 1'b1, "R4", "sqrt(2.0) inexact", 128'(flag_inexact), 128'd1);

        // R5 zeros and +infinity
        op_check("R5", rnd128(), 16'h0000, 16'h0, 1'b1, 1'b1, 1'b0, 2'b10);
        op_check("R5", rnd128(), 16'h8000, 16'h0, 1'b1, 1'b1, 1'b0, 2'b00);
        op_check("R5", rnd128(), 16'h7C00, 16'h0, 1'b0, 1'b0, 1'b0, 2'b11);
        // R6 negatives
        op_check("R6", rnd128(), 16'hFC00, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        op_check("R6", rnd128(), 16'hBC00, 16'h0, 1'b0, 1'b0, 1'b0, 2'b01);
        op_check("R6", rnd128(), 16'h8001, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        // R7 NaNs
        op_check("R7", rnd128(), 16'h7C01, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        op_check("R7", rnd128(), 16'hFE12, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        // R8 smallest and largest subnormals
        op_check("R8", rnd128(), 16'h0001, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00);
        op_check("R8", rnd128(), 16'h03FF, 16'h0, 1'b0, 1'b0, 1'b0, 2'b10);
        // R3 every mode on the largest finite value
        for (int md = 0; md < 4; md++)
            op_check("R3", rnd128(), 16'h7BFF, 16'h0, 1'b0, 1'b0, 1'b0, 2'(md));

        // R9 mask with exceptions in the same completion cycle
        op_check("R9", rnd128(), 16'h7C01, 16'hBEEF, 1'b0, 1'b1, 1'b1, 2'b00);
        op_check("R9", rnd128(), 16'h8001, 16'hBEEF, 1'b0, 1'b1, 1'b0, 2'b00);
        op_check("R9", rnd128(), 16'h4000, 16'hCAFE, 1'b0, 1'b1, 1'b0, 2'b10);
        op_check("R9", rnd128(), 16'h4000, 16'hCAFE, 1'b0, 1'b0, 1'b1, 2'b00);

        // R10 start while busy and input changes are ignored
        begin
            int seen = 0;
            upper_src = 128'h1; root_src = 128'h4400; prior_low = '0;
            lane_mask = 1'b1; mask_on = 1'b0; zero_on = 1'b0; rnd_mode = 2'b00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            upper_src = 128'hFFFF_0000; root_src = 128'h7C01;
            lane_mask = 1'b0; mask_on = 1'b1; zero_on = 1'b1; rnd_mode = 2'b10;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n = 5;
            while (!done && n < 40) begin @(negedge clk); n++; end
            check(result == 128'h0000_4000 && n == 14 && !flag_invalid, "R10",
                  "busy start ignored", result, 128'h0000_4000);
            repeat (20) begin @(negedge clk); if (done) seen++; end
            check(seen == 0, "R10", "no extra done", 128'(seen), 128'd0);
        end

        // sweep over a stride of all codes, cycling modes and masks
        for (int k = 0; k < 65536; k += 9) begin
            string tag;
            logic [1:0] md = 2'((k / 9) % 4);
            bit masked = ((k / 9) % 7) == 3;
            x = 16'(k);
            if (masked) tag = "R9";
            else if (x[14:10] == 5'h1F) tag = (x[9:0] == 0 && !x[15]) ? "R5" : "R7";
            else if (x[14:0] == 0) tag = "R5";
            else if (x[15]) tag = "R6";
            else if (x[14:10] == 0) tag = "R8";
            else tag = (md == 2'b00) ? "R2" : "R3";
            op_check(tag, rnd128(), x, 16'(k * 5), !masked, 1'b1, k[0], md);
        end

        if (!fin) begin
            fin = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule